// File: doc/BRIEF.md
# Voice Codec Power State Controller

This block picks the power state of a single-channel voice codec. Three inputs drive the choice. The first is an active-low power-down pin. The second is the serial bit clock, and the third is the transmit frame sync. All three are sampled by a free-running system clock. The block has three states: running, power-save and power-down.

- A low power-down pin forces power-down. This takes priority over everything else.
- If the bit clock or the frame sync stops toggling for longer than its own timeout, the block drops from running to power-save.
- Coming back to running always needs two valid frames in a row. A valid frame is a sync rising edge that arrives within the sync timeout of the previous one, while the bit clock is alive.

The controller drives three per-state flags: one enables the serial port, one holds the serial data output at high impedance, and one tells the analog stages to rest at signal ground. It also reports the encoded state and gives a one-cycle pulse on every state change. The default timeouts assume a 125 MHz system clock:

- The bit-clock timeout is about four periods of a 64 kHz bit clock.
- The sync timeout is about two frame periods at 6 kHz, the slowest permitted frame rate.

Top module: `codec_pwr_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the state is power-save (2'b01). In that state the change pulse is 0, the serial enable is 0, and the high-impedance and rest-at-ground flags are 1.
- R2: The state encoding is 2'b00 running, 2'b01 power-save and 2'b10 power-down, and 2'b11 never appears. The serial enable is 1 only in running. The high-impedance and rest-at-ground flags are 1 in both low-power states and 0 in running.
- R3: A low power-down pin puts the block in power-down. This holds whatever the bit clock and the frame sync are doing, and the block stays there while the pin is low.
- R4: In running, when no edge of either polarity on the bit clock has been seen for BIT_IDLE_CYC system cycles, the block moves to power-save. This applies with the clock stuck high and with it stuck low.
- R5: In running, when no rising edge of the frame sync has been seen for FRAME_IDLE_CYC system cycles, the block moves to power-save. This applies with the sync stuck high and with it stuck low.
- R6: The block moves from power-save to running only after FRAMES_TO_WAKE (default 2) consecutive valid frames.
  - A valid frame is a sync rising edge that arrives within FRAME_IDLE_CYC cycles of the previous rising edge, while the pin is high and the bit clock is not idle.
  - The first rising edge after a sync timeout never counts.
  - A sync whose period is longer than the timeout never brings the block back to running.
- R7: When the power-down pin is released, the block moves to power-save, never directly to running.
- R8: The change pulse is 1 for exactly one cycle, and only in the cycle in which the reported state differs from the state of the previous cycle.
- R9: Each input passes through SYNC_STAGES flip-flops before it is used. With the default of 2, a power-down pin that falls just after a clock edge shows as state 2'b10 after the third rising clock edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down_n | input | 1 | Power-down pin, low forces power-down |
| bit_clk | input | 1 | Serial bit clock, asynchronous to clk |
| tx_frame | input | 1 | Transmit frame sync, asynchronous to clk |
| pm_state | output | 2 | Encoded power state (00 run, 01 save, 10 down) |
| pm_change | output | 1 | One-cycle pulse on each state change |
| serial_en | output | 1 | Serial port enable, 1 only when running |
| sdo_hiz | output | 1 | Hold serial data output at high impedance |
| analog_park | output | 1 | Command analog outputs to signal-ground level |

## Verification
A watchdog count that is off by one shows at the ports as a state drop that comes one cycle early or late. The drop comes BIT_IDLE_CYC or FRAME_IDLE_CYC cycles after the last edge. A frame qualifier that loses count shows as a return to running after the wrong number of sync rising edges. The bench counts those edges at the pin and expects exactly three after a cold start. A wrong priority or a wrong transition shows within three cycles of the pin moving, as a wrong pm_state or a missing pm_change pulse. The bench's cycle model compares every port on every clock, so any of these faults is reported in the cycle where it first appears.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

  typedef enum logic [1:0] {
    CPC_RUN  = 2'b00,
    CPC_SAVE = 2'b01,
    CPC_DOWN = 2'b10
  } cpc_mode_e;

  typedef struct packed {
    logic serial_en;
    logic hiz;
    logic park;
  } cpc_flags_t;

  // State transition rule: the pin wins, idle drops out of run,
  // a qualified frame train brings save back to run.
  function automatic cpc_mode_e cpc_next_mode(cpc_mode_e cur, logic pin_ok,
                                              logic idle, logic qualified);
    if (!pin_ok) return CPC_DOWN;
    case (cur)
      CPC_RUN:  return idle ? CPC_SAVE : CPC_RUN;
      CPC_SAVE: return (qualified && !idle) ? CPC_RUN : CPC_SAVE;
      default:  return CPC_SAVE;
    endcase
  endfunction

  function automatic cpc_flags_t cpc_flags(cpc_mode_e m);
    cpc_flags_t f;
    f.serial_en = (m == CPC_RUN);
    f.hiz       = (m != CPC_RUN);
    f.park      = (m != CPC_RUN);
    return f;
  endfunction

  // Saturating increment toward a limit.
  function automatic int unsigned cpc_sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/cpc_sync.sv
module cpc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic prv
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {(STAGES + 1){RST_VAL}};
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign lvl = sh[STAGES-1];
  assign prv = sh[STAGES];
endmodule

// File: rtl/cpc_activity.sv
module cpc_activity #(
  parameter int LIMIT     = 8000,
  parameter bit RISE_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic prv,
  output logic hit,
  output logic stalled
);
  import cpc_pkg::*;
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = LIMIT[CW-1:0];

  logic [CW-1:0] age;

  generate
    if (RISE_ONLY) begin : g_rise
      assign hit = lvl & ~prv;
    end else begin : g_any
      assign hit = lvl ^ prv;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   age <= LIM_V;
    else if (hit) age <= '0;
    else          age <= CW'(cpc_sat_inc(int'(age), LIMIT));
  end

  assign stalled = (age == LIM_V);

  // R4
  hit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !stalled);
  // R5
  quiet_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && !hit) |=> stalled);
endmodule

// File: rtl/cpc_qualify.sv
module cpc_qualify #(
  parameter int NEED = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_ok,
  input  logic b_stall,
  input  logic x_stall,
  input  logic x_hit,
  output logic ready
);
  localparam int CW = $clog2(NEED + 1);
  localparam logic [CW-1:0] NEED_V = NEED[CW-1:0];

  logic [CW-1:0] frames;
  logic          spoil;
  assign spoil = !pin_ok || b_stall || x_stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        frames <= '0;
    else if (spoil)                    frames <= '0;
    else if (x_hit && frames != NEED_V) frames <= frames + 1'b1;
  end

  assign ready = (frames == NEED_V);

  // R6
  ready_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(x_hit));
endmodule

// File: rtl/cpc_fsm.sv
module cpc_fsm (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_ok,
  input  logic              idle,
  input  logic              ready,
  output cpc_pkg::cpc_mode_e mode,
  output logic              chg
);
  import cpc_pkg::*;
  cpc_mode_e mode_q, mode_nx;
  logic      chg_q;

  assign mode_nx = cpc_next_mode(mode_q, pin_ok, idle, ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CPC_SAVE;
      chg_q  <= 1'b0;
    end else begin
      mode_q <= mode_nx;
      chg_q  <= (mode_nx != mode_q);
    end
  end

  assign mode = mode_q;
  assign chg  = chg_q;

  // R3
  pin_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_ok |=> mode_q == CPC_DOWN);
  // R4
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CPC_RUN && idle && pin_ok) |=> mode_q == CPC_SAVE);
  // R6
  run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CPC_RUN && $past(mode_q) != CPC_RUN) |-> $past(mode_q) == CPC_SAVE);
  // R8
  chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q == (mode_q != $past(mode_q)));
endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl #(
  parameter int BIT_IDLE_CYC   = 8000,
  parameter int FRAME_IDLE_CYC = 41667,
  parameter int FRAMES_TO_WAKE = 2,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_down_n,
  input  logic       bit_clk,
  input  logic       tx_frame,
  output logic [1:0] pm_state,
  output logic       pm_change,
  output logic       serial_en,
  output logic       sdo_hiz,
  output logic       analog_park
);
  import cpc_pkg::*;

  logic pin_lvl, pin_prv;
  logic b_lvl, b_prv, b_hit, b_stall;
  logic x_lvl, x_prv, x_hit, x_stall;
  logic idle, ready;
  cpc_mode_e  mode;
  cpc_flags_t flags;

  cpc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .din(pwr_down_n), .lvl(pin_lvl), .prv(pin_prv));
  cpc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bclk_sync (
    .clk(clk), .rst_n(rst_n), .din(bit_clk), .lvl(b_lvl), .prv(b_prv));
  cpc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_frame_sync (
    .clk(clk), .rst_n(rst_n), .din(tx_frame), .lvl(x_lvl), .prv(x_prv));

  cpc_activity #(.LIMIT(BIT_IDLE_CYC), .RISE_ONLY(1'b0)) u_bclk_mon (
    .clk(clk), .rst_n(rst_n), .lvl(b_lvl), .prv(b_prv),
    .hit(b_hit), .stalled(b_stall));
  cpc_activity #(.LIMIT(FRAME_IDLE_CYC), .RISE_ONLY(1'b1)) u_frame_mon (
    .clk(clk), .rst_n(rst_n), .lvl(x_lvl), .prv(x_prv),
    .hit(x_hit), .stalled(x_stall));

  cpc_qualify #(.NEED(FRAMES_TO_WAKE)) u_qual (
    .clk(clk), .rst_n(rst_n), .pin_ok(pin_lvl), .b_stall(b_stall),
    .x_stall(x_stall), .x_hit(x_hit), .ready(ready));

  assign idle = b_stall | x_stall;

  cpc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pin_ok(pin_lvl), .idle(idle),
    .ready(ready), .mode(mode), .chg(pm_change));

  assign flags       = cpc_flags(mode);
  assign pm_state    = mode;
  assign serial_en   = flags.serial_en;
  assign sdo_hiz     = flags.hiz;
  assign analog_park = flags.park;

  // R2
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_state != 2'b11);
  // R7
  pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_lvl && !pin_prv) |=> pm_state == CPC_SAVE);
  // R4
  bclk_edge_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_hit && pm_state == CPC_RUN && pin_lvl && !x_stall) |=> pm_state == CPC_RUN);
endmodule

// File: tb/tb_codec_pwr_ctrl.sv
module tb_codec_pwr_ctrl;
  localparam int BL = 40;
  localparam int SL = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_down_n = 1'b1;
  logic bit_clk = 1'b0;
  logic tx_frame = 1'b0;
  logic [1:0] pm_state;
  logic pm_change, serial_en, sdo_hiz, analog_park;

  codec_pwr_ctrl #(.BIT_IDLE_CYC(BL), .FRAME_IDLE_CYC(SL),
                   .FRAMES_TO_WAKE(2), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_down_n(pwr_down_n), .bit_clk(bit_clk),
    .tx_frame(tx_frame), .pm_state(pm_state), .pm_change(pm_change),
    .serial_en(serial_en), .sdo_hiz(sdo_hiz), .analog_park(analog_park));

  always #4 clk = ~clk;  // 125 MHz

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Stimulus generator controls
  bit bclk_run = 0, bclk_hold = 0;
  bit sync_run = 0, sync_hold = 0;
  int sync_per = 128;
  int rises = 0;

  initial begin
    int bc = 0;
    int xc = 0;
    forever begin
      @(negedge clk);
      if (bclk_run) begin
        bc++;
        if (bc >= 4) begin bit_clk = ~bit_clk; bc = 0; end
      end else bit_clk = bclk_hold;
      if (sync_run) begin
        if (!tx_frame && xc < 8) rises++;
        tx_frame = (xc < 8);
        xc = (xc + 1 >= sync_per) ? 0 : xc + 1;
      end else begin
        if (!tx_frame && sync_hold) rises++;
        tx_frame = sync_hold;
      end
    end
  end

  // Behavioural reference: input histories as queues, ages as integers
  bit  hb[$], hx[$], hp[$];
  int  b_age, x_age, frames, m_mode, m_prev;
  bit  m_chg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb = '{0, 0, 0}; hx = '{0, 0, 0}; hp = '{1, 1};
      b_age = BL; x_age = SL; frames = 0; m_mode = 1; m_chg = 0;
    end else begin
      bit bh, xh, bst, xst, ok, idl;
      int nm;
      bh  = (hb[1] != hb[2]);
      xh  = hx[1] && !hx[2];
      bst = (b_age == BL);
      xst = (x_age == SL);
      ok  = hp[1];
      idl = bst || xst;
      if (!ok) nm = 2;
      else if (m_mode == 0) nm = idl ? 1 : 0;
      else if (m_mode == 1) nm = (frames == 2 && !idl) ? 0 : 1;
      else nm = 1;
      m_chg = (nm != m_mode);
      m_mode = nm;
      if (!ok || idl) frames = 0;
      else if (xh && frames < 2) frames++;
      b_age = bh ? 0 : (b_age < BL ? b_age + 1 : BL);
      x_age = xh ? 0 : (x_age < SL ? x_age + 1 : SL);
      hb.push_front(bit_clk);     void'(hb.pop_back());
      hx.push_front(tx_frame);    void'(hx.pop_back());
      hp.push_front(pwr_down_n);  void'(hp.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 state vs model", pm_state, m_mode);
      check("R8 change pulse", pm_change, m_chg);
      check("R2 serial enable", serial_en, m_mode == 0);
      check("R2 hiz flag", sdo_hiz, m_mode != 0);
      check("R2 park flag", analog_park, m_mode != 0);
    end
  end

  task automatic wait_state(int exp, int max, string tag);
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (pm_state == exp) break;
    end
    check(tag, pm_state, exp);
  endtask

  task automatic idle_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle_cyc(5);
    // R1 reset values seen while reset is held
    check("R1 reset state", pm_state, 1);
    check("R1 reset pulse", pm_change, 0);
    check("R1 reset serial enable", serial_en, 0);
    check("R1 reset hiz", sdo_hiz, 1);
    check("R1 reset park", analog_park, 1);
    rst_n = 1'b1;
    idle_cyc(1);
    check("R1 first cycle state", pm_state, 1);

    // R6 cold start: exactly three sync rises before run
    rises = 0; bclk_run = 1; sync_run = 1; sync_per = 128;
    for (int i = 0; i < 1000 && pm_state != 0; i++) @(negedge clk);
    check("R6 run after cold start", pm_state, 0);
    check("R6 rises needed", rises, 3);

    // R5 slow sync: period above timeout drops to save and never returns
    sync_per = 260;
    idle_cyc(1500);
    check("R5 R6 slow sync stays in save", pm_state, 1);
    sync_per = 128;
    wait_state(0, 1000, "R6 return to run");

    // R4 bit clock stuck high
    bclk_run = 0; bclk_hold = bit_clk;
    idle_cyc(20);
    check("R4 no early drop", pm_state, 0);
    idle_cyc(40);
    check("R4 stuck clock save", pm_state, 1);
    bclk_run = 1;
    wait_state(0, 1000, "R6 run after clock restart");
    bclk_run = 0; bclk_hold = 1'b0;
    idle_cyc(60);
    check("R4 stuck low save", pm_state, 1);
    bclk_run = 1;
    wait_state(0, 1000, "R6 run again");

    // R5 sync stuck high then low
    sync_run = 0; sync_hold = 1'b1;
    idle_cyc(260);
    check("R5 sync stuck high", pm_state, 1);
    sync_run = 1;
    wait_state(0, 1000, "R6 run after sync restart");
    sync_run = 0; sync_hold = 1'b0;
    idle_cyc(260);
    check("R5 sync stuck low", pm_state, 1);
    sync_run = 1;
    wait_state(0, 1000, "R6 run before pin test");

    // R9 latency and R3 priority
    pwr_down_n = 1'b0;
    idle_cyc(2);
    check("R9 pin not yet seen", pm_state, 0);
    idle_cyc(1);
    check("R3 power down", pm_state, 2);
    bclk_run = 0; sync_run = 0;
    idle_cyc(300);
    check("R3 stays down with idle clocks", pm_state, 2);
    bclk_run = 1; sync_run = 1;
    idle_cyc(300);
    check("R3 stays down with live clocks", pm_state, 2);

    // R7 release goes through save
    pwr_down_n = 1'b1;
    for (int i = 0; i < 10 && pm_state == 2; i++) @(negedge clk);
    check("R7 release to save", pm_state, 1);
    wait_state(0, 1000, "R7 later run");

    idle_cyc(20);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule